// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block takes one long vector job of `n` elements and cuts it into strips that each fit the hardware's maximum vector length (`MVL`, a power of two, 64 by default). For each strip it presents the element count to load into the vector length register and the index of the strip's first element. The execution side works on the presented strip and signals completion with a one-cycle handshake. The sequencer then presents the next strip, or raises its done flag once all strips are finished.

The odd-size piece (`n mod MVL`) is issued first. Every strip after it has exactly `MVL` elements, so the strip loop needs no length check after the first strip. A job whose length is an exact multiple of `MVL` has no odd piece, and its first strip is already full length. The element index starts at zero and grows by the length of each completed strip. Generating memory addresses and executing the vector work are handled elsewhere.

Top module: `strip_seq`

## Requirements
- R1: When a start pulse is accepted and `n mod MVL` is nonzero, the first strip appears on the next cycle with `stripVl = n mod MVL` (the low log2(MVL) bits of `vecLen`) and `stripBase = 0`.
- R2: When `n mod MVL` is zero and `n` is nonzero, no zero-length strip is emitted, and the first strip has `stripVl = MVL`.
- R3: Every strip after the first has `stripVl = MVL`. A job produces `floor(n/MVL)` full strips plus one odd strip when `n mod MVL` is nonzero.
- R4: After each completed strip, `stripBase` grows by that strip's length. Once the job is done, `stripBase` equals `n`.
- R5: A start with `n = 0` raises `allDone` on the next cycle, and `stripValid` never rises for that job.
- R6: A strip is completed on a cycle where `stripValid` and `stripDone` are both high. While `stripDone` is low, `stripValid`, `stripVl` and `stripBase` hold their values. The next strip appears on the cycle right after the completion.
- R7: `allDone` rises on the cycle after the last strip completes, in the same cycle that `stripValid` falls. It stays high until the next accepted start clears it. `allDone` and `stripValid` are never high together.
- R8: A start pulse arriving while a strip is valid is ignored. The running job keeps its strips and ends with `stripBase = n` of the original job.
- R9: A `stripDone` pulse arriving while no strip is valid has no effect on any output.
- R10: After reset, `stripValid`, `allDone`, `stripVl` and `stripBase` are all zero.
- R11: `stripVl` is log2(MVL)+1 bits wide so that it can carry the value `MVL`. With the default parameters, a full strip reads binary 1000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when no strip is valid |
| vecLen | input | LEN_W | Total element count `n`, sampled on an accepted start |
| stripDone | input | 1 | Execution side finished the presented strip |
| stripVl | output | log2(MVL)+1 | Vector length for the current strip |
| stripBase | output | LEN_W | Index of the current strip's first element |
| stripValid | output | 1 | A strip is presented and awaiting completion |
| allDone | output | 1 | Job finished; held until the next accepted start |

## Verification
The hardest cases to reach from the ports are the collisions at the block's edge. One is a start pulse arriving while a strip is outstanding. Another is a completion arriving while the block sits idle and done. A third is a completion given in the very cycle a strip first appears. The stimulus forces each of these on purpose: a second start with a different length is injected mid-job, a stray `stripDone` is pulsed after completion, and completions are issued with zero, one and two cycles of wait. Lengths of 0, exact multiples of `MVL`, `MVL-1`, and large values with a small remainder cover the skipped-remainder and single-strip boundaries.

// File: rtl/strip_pkg.sv
package strip_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } stripState_e;

  typedef struct packed {
    logic loadJob;   // capture a new job and its first strip
    logic takeRem;   // first strip is the odd remainder
    logic takeFull;  // next strip is a full MVL strip
    logic advance;   // current strip completed, move base on
  } stripCtrl_t;

endpackage

// File: rtl/strip_dp.sv
module strip_dp
  import strip_pkg::*;
#(
  parameter int MVL   = 64,
  parameter int LEN_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  stripCtrl_t               ctrl,
  input  logic [LEN_W-1:0]         vecLen,
  output logic [$clog2(MVL):0]     stripVl,
  output logic [LEN_W-1:0]         stripBase,
  output logic                     remNz,
  output logic                     fullNz,
  output logic                     moreFull
);

  localparam int LOG    = $clog2(MVL);
  localparam int VL_W   = LOG + 1;
  localparam int FULL_W = LEN_W - LOG;
  localparam logic [VL_W-1:0] VL_MAX = VL_W'(MVL);

  logic [LOG-1:0]    remPart;
  logic [FULL_W-1:0] fullPart;
  logic [FULL_W-1:0] fullLeft;
  logic [VL_W-1:0]   vlReg;
  logic [LEN_W-1:0]  baseReg;

  assign remPart  = vecLen[LOG-1:0];
  assign fullPart = vecLen[LEN_W-1:LOG];
  assign remNz    = (remPart != '0);
  assign fullNz   = (fullPart != '0);
  assign moreFull = (fullLeft != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vlReg    <= '0;
      baseReg  <= '0;
      fullLeft <= '0;
    end else if (ctrl.loadJob) begin
      baseReg <= '0;
      if (ctrl.takeRem) begin
        vlReg    <= {1'b0, remPart};
        fullLeft <= fullPart;
      end else if (ctrl.takeFull) begin
        vlReg    <= VL_MAX;
        fullLeft <= fullPart - FULL_W'(1);
      end else begin
        vlReg    <= '0;
        fullLeft <= '0;
      end
    end else if (ctrl.advance) begin
      baseReg <= baseReg + LEN_W'(vlReg);
      if (ctrl.takeFull) begin
        vlReg    <= VL_MAX;
        fullLeft <= fullLeft - FULL_W'(1);
      end
    end
  end

  assign stripVl   = vlReg;
  assign stripBase = baseReg;

  // The full-strip counter only decrements while it still has strips left.
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.advance && ctrl.takeFull) |-> moreFull)
    else $error("full strip taken with none left"); // R3

endmodule

// File: rtl/strip_ctrl.sv
module strip_ctrl
  import strip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stripDone,
  input  logic       remNz,
  input  logic       fullNz,
  input  logic       moreFull,
  output stripCtrl_t ctrl,
  output logic       stripValid,
  output logic       allDone
);

  stripState_e state, stateNxt;
  logic        validNxt, doneNxt;
  logic        anyStrip;

  assign anyStrip = remNz | fullNz;

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    validNxt = stripValid;
    doneNxt  = allDone;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.loadJob  = 1'b1;
          ctrl.takeRem  = remNz;
          ctrl.takeFull = !remNz && fullNz;
          validNxt      = anyStrip;
          doneNxt       = !anyStrip;
          stateNxt      = anyStrip ? ST_RUN : ST_IDLE;
        end
      end
      ST_RUN: begin
        if (stripDone) begin
          ctrl.advance  = 1'b1;
          ctrl.takeFull = moreFull;
          if (!moreFull) begin
            validNxt = 1'b0;
            doneNxt  = 1'b1;
            stateNxt = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      stripValid <= 1'b0;
      allDone    <= 1'b0;
    end else begin
      state      <= stateNxt;
      stripValid <= validNxt;
      allDone    <= doneNxt;
    end
  end

  AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stripValid && allDone))
    else $error("valid and done together"); // R7

  AST_EMPTY_JOB_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !remNz && !fullNz) |=> (allDone && !stripValid))
    else $error("empty job did not finish at once"); // R5

  AST_IDLE_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stripValid && allDone && !start) |=> allDone)
    else $error("done dropped without start"); // R7

endmodule

// File: rtl/strip_seq.sv
module strip_seq
  import strip_pkg::*;
#(
  parameter int MVL   = 64,
  parameter int LEN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LEN_W-1:0]     vecLen,
  input  logic                 stripDone,
  output logic [$clog2(MVL):0] stripVl,
  output logic [LEN_W-1:0]     stripBase,
  output logic                 stripValid,
  output logic                 allDone
);

  localparam int VL_W = $clog2(MVL) + 1;
  localparam logic [VL_W-1:0] VL_MAX = VL_W'(MVL);

  stripCtrl_t ctrl;
  logic       remNz, fullNz, moreFull;

  strip_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stripDone  (stripDone),
    .remNz      (remNz),
    .fullNz     (fullNz),
    .moreFull   (moreFull),
    .ctrl       (ctrl),
    .stripValid (stripValid),
    .allDone    (allDone)
  );

  strip_dp #(.MVL(MVL), .LEN_W(LEN_W)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .vecLen    (vecLen),
    .stripVl   (stripVl),
    .stripBase (stripBase),
    .remNz     (remNz),
    .fullNz    (fullNz),
    .moreFull  (moreFull)
  );

  AST_VL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    stripValid |-> (stripVl != '0 && stripVl <= VL_MAX))
    else $error("strip length out of range"); // R2

  AST_LATER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (stripValid && $past(stripValid && stripDone)) |-> (stripVl == VL_MAX))
    else $error("later strip not full"); // R3

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stripValid && stripDone) |-> (stripBase == $past(stripBase) + LEN_W'($past(stripVl))))
    else $error("base did not step by strip length"); // R4

  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stripValid && !stripDone) |=> (stripValid && $stable(stripVl) && $stable(stripBase)))
    else $error("strip changed without completion"); // R6

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (stripValid && start && !stripDone) |=> (stripValid && $stable(stripBase)))
    else $error("start disturbed running job"); // R8

  AST_IDLE_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stripValid && !start) |=> ($stable(stripBase) && !stripValid))
    else $error("idle completion pulse had effect"); // R9

endmodule

// File: tb/test_strip_seq.sv
`timescale 1ns/1ps
module test_strip_seq;

  localparam int MVL   = 64;
  localparam int LEN_W = 16;
  localparam int VL_W  = $clog2(MVL) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] vecLen = '0;
  logic             stripDone = 1'b0;
  logic [VL_W-1:0]  stripVl;
  logic [LEN_W-1:0] stripBase;
  logic             stripValid;
  logic             allDone;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 1'b0;
  string curReq = "R10";

  always #4 clk = ~clk;

  strip_seq #(.MVL(MVL), .LEN_W(LEN_W)) i_strip_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vecLen(vecLen),
    .stripDone(stripDone), .stripVl(stripVl), .stripBase(stripBase),
    .stripValid(stripValid), .allDone(allDone)
  );

  // Behavioural reference: a queue of pending strip lengths.
  int queue_t[$];
  int mVl = 0, mBase = 0;
  bit mValid = 0, mDone = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      queue_t.delete();
      mVl = 0; mBase = 0; mValid = 0; mDone = 0;
    end else if (!mValid && start) begin
      int n;
      n = int'(vecLen);
      queue_t.delete();
      if (n % MVL != 0) queue_t.push_back(n % MVL);
      for (int k = 0; k < n / MVL; k++) queue_t.push_back(MVL);
      mBase = 0;
      if (queue_t.size() == 0) begin
        mVl = 0; mDone = 1; mValid = 0;
      end else begin
        mVl = queue_t.pop_front(); mValid = 1; mDone = 0;
      end
    end else if (mValid && stripDone) begin
      mBase = mBase + mVl;
      if (queue_t.size() != 0) mVl = queue_t.pop_front();
      else begin mValid = 0; mDone = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (int'(stripVl) != mVl || int'(stripBase) != mBase ||
          stripValid != mValid || allDone != mDone) begin
        failures++;
        $display("FAIL %s model compare: vl=%0d base=%0d valid=%0b done=%0b expected vl=%0d base=%0d valid=%0b done=%0b",
                 curReq, stripVl, stripBase, stripValid, allDone, mVl, mBase, mValid, mDone);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseStart(input int n);
    @(negedge clk); start = 1'b1; vecLen = LEN_W'(n);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic completeOne(input int gap);
    repeat (gap) @(negedge clk);
    stripDone = 1'b1;
    @(negedge clk); stripDone = 1'b0;
  endtask

  task automatic runJob(input int n, input int gap);
    int idx;
    idx = 0;
    pulseStart(n);
    while (!allDone) begin
      if (stripValid) begin
        completeOne((gap + idx) % 3);
        idx++;
      end else @(negedge clk);
    end
    chk(int'(stripBase) == n, "R4 final base", int'(stripBase), n);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset values
    chk(stripValid == 0, "R10 valid", stripValid, 0);
    chk(allDone == 0,    "R10 done", allDone, 0);
    chk(stripVl == 0,    "R10 vl", stripVl, 0);
    chk(stripBase == 0,  "R10 base", stripBase, 0);

    // R5 empty job
    curReq = "R5";
    @(negedge clk); start = 1'b1; vecLen = '0;
    @(negedge clk); start = 1'b0;
    chk(allDone == 1,    "R5 done next cycle", allDone, 1);
    chk(stripValid == 0, "R5 no strip", stripValid, 0);

    // R1 / R3 / R4 / R6 / R7 with n=130 -> 2, 64, 64
    curReq = "R1";
    pulseStart(130);
    chk(stripVl == 2,    "R1 first vl", stripVl, 2);
    chk(stripBase == 0,  "R1 first base", stripBase, 0);
    chk(allDone == 0,    "R7 done cleared by start", allDone, 0);
    curReq = "R3";
    completeOne(0);
    chk(stripVl == 64,   "R3 second vl", stripVl, 64);
    chk(stripBase == 2,  "R4 second base", stripBase, 2);
    curReq = "R6";
    repeat (3) @(negedge clk);
    chk(stripValid == 1 && stripVl == 64 && stripBase == 2, "R6 hold while waiting", stripBase, 2);
    completeOne(0);
    chk(stripVl == 64,   "R3 third vl", stripVl, 64);
    chk(stripBase == 66, "R4 third base", stripBase, 66);
    curReq = "R7";
    completeOne(1);
    chk(allDone == 1 && stripValid == 0, "R7 done after last strip", allDone, 1);
    chk(stripBase == 130, "R4 final base 130", stripBase, 130);
    repeat (3) @(negedge clk);
    chk(allDone == 1,    "R7 done held", allDone, 1);

    // R9 stray completion while idle
    curReq = "R9";
    stripDone = 1'b1;
    @(negedge clk); stripDone = 1'b0;
    @(negedge clk);
    chk(stripBase == 130 && stripValid == 0 && allDone == 1, "R9 idle stripDone ignored", stripBase, 130);

    // R2 / R11 exact multiple
    curReq = "R2";
    pulseStart(128);
    chk(stripVl == 64,   "R2 first strip full", stripVl, 64);
    chk(stripVl == 7'b1000000, "R11 vl encodes MVL", stripVl, 64);
    completeOne(2);
    chk(stripVl == 64 && stripBase == 64, "R2 second strip", stripBase, 64);
    completeOne(0);
    chk(allDone == 1 && stripBase == 128, "R2 two strips only", stripBase, 128);

    // R8 start while busy
    curReq = "R8";
    pulseStart(200);
    chk(stripVl == 8,    "R8 first vl of 200", stripVl, 8);
    @(negedge clk); start = 1'b1; vecLen = LEN_W'(3);
    @(negedge clk); start = 1'b0;
    chk(stripVl == 8 && stripBase == 0 && stripValid == 1, "R8 busy start ignored", stripVl, 8);
    while (!allDone) begin
      if (stripValid) completeOne(1); else @(negedge clk);
    end
    chk(stripBase == 200, "R8 original job completed", stripBase, 200);

    // Assorted lengths
    curReq = "R3";
    runJob(5, 0);
    runJob(64, 1);
    runJob(63, 2);
    runJob(1000, 0);
    runJob(4097, 1);
    curReq = "R1";
    runJob(1, 0);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule